// File: doc/BRIEF.md
# T1/E1 Datalink Overhead Port

This block sits between a framer's serial bit stream and an external overhead device. It follows the bit position inside the T1 extended-superframe or E1 frame structure, independently for the transmit and the receive stream. At every datalink bit position it raises an overhead strobe toward the external device. On transmit, the bit that the device supplies replaces the PCM bit at that position. On receive, the PCM bit at that position is copied to a datalink output, and the PCM stream itself passes through unchanged.

The block runs on a single clock, one cycle per serial bit. Each overhead strobe is a registered signal that is high for exactly one bit period per datalink bit. The external device launches transmit data on the strobe's rising edge. The block captures that data on the strobe's falling edge, which is the next rising edge of the bit clock. The extracted receive bit changes on the rising edge of the receive strobe.

The mode input selects the framing: 0 is T1 ESF and 1 is E1. The enable input selects where the datalink comes from. When it is clear, the datalink stays inside the PCM data and the external port is ignored.

Top module: `dl_overhead_port`

## Requirements
- R1: While rst_n is low, tx_ser_out, tx_oh_clk, rx_ser_out, rx_oh_clk and rx_oh_data are all 0.
- R2: With ext_en low, tx_oh_clk and rx_oh_clk stay 0. tx_ser_out equals tx_ser_in two cycles earlier, whatever tx_oh_data does. rx_oh_data holds its value.
- R3: In T1 mode (mode=0), a frame is 193 bits and bit 0 is the F bit. Frames are indexed 0..23 within the multiframe. With ext_en high, tx_oh_clk is high for exactly one cycle, in the cycle after tx_ser_in carries the F bit of an even-indexed frame. This gives 12 pulses per multiframe.
- R4: In E1 mode (mode=1), a frame is 256 bits and frames alternate between alignment and non-alignment frames. With ext_en high, tx_oh_clk is high in the cycle after each of frame bits 3..7 (timeslot 0, bit numbers 4..8) of a non-alignment frame. That is 5 consecutive pulses per non-alignment frame and none in alignment frames.
- R5: tx_ser_out carries each input bit two cycles after it was on tx_ser_in. At a datalink position it carries instead the tx_oh_data value present at the clock edge that ends the tx_oh_clk high cycle. All other bits, including E1 timeslot 0 bits 0..2, are unchanged.
- R6: rx_oh_clk follows the same position rules as R3/R4 for the receive stream, high in the cycle after the datalink bit is on rx_ser_in.
- R7: rx_oh_data takes the datalink bit from rx_ser_in on the same edge on which rx_oh_clk rises. It holds its value whenever rx_oh_clk is low.
- R8: rx_ser_out equals rx_ser_in one cycle earlier, in every mode and enable setting.
- R9: A high *_fsync marks bit 0 of a frame and realigns the bit count at once. In T1 mode, *_msync high together with *_fsync marks frame index 0. In E1 mode, *_fas high with *_fsync marks an alignment frame and low marks a non-alignment frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = T1 ESF, 1 = E1 |
| ext_en | input | 1 | 1 = datalink via external port |
| tx_fsync | input | 1 | Transmit frame start (bit 0) |
| tx_msync | input | 1 | Transmit multiframe start, with tx_fsync |
| tx_fas | input | 1 | Transmit E1 alignment-frame flag, with tx_fsync |
| tx_ser_in | input | 1 | Transmit PCM bit from the framer |
| tx_ser_out | output | 1 | Transmit PCM bit toward the line |
| tx_oh_clk | output | 1 | Transmit overhead strobe |
| tx_oh_data | input | 1 | Datalink bit from the external device |
| rx_fsync | input | 1 | Receive frame start (bit 0) |
| rx_msync | input | 1 | Receive multiframe start, with rx_fsync |
| rx_fas | input | 1 | Receive E1 alignment-frame flag, with rx_fsync |
| rx_ser_in | input | 1 | Receive PCM bit from the line |
| rx_ser_out | output | 1 | Receive PCM bit, unaltered |
| rx_oh_clk | output | 1 | Receive overhead strobe |
| rx_oh_data | output | 1 | Extracted receive datalink bit |

## Verification
The strobes, rx_ser_out and rx_oh_data are due one cycle after the bit that caused them is presented. tx_ser_out is due two cycles after its input bit. Its inserted value is the tx_oh_data level present one cycle after the strobe rises. The bench drives every input on the falling edge and samples on the next falling edge. It keeps a one-cycle history of its own transmit inputs and strobe expectation, so each output is compared against the stimulus cycle that produced it. Positions come from arithmetic on a bench-side bit index. Pulse totals per multiframe or per frame pair are compared against 12 and 5 per non-alignment frame.

// File: rtl/dl_ovh_pkg.sv
`timescale 1ns/1ps
package dl_ovh_pkg;

  typedef enum logic {
    MODE_T1 = 1'b0,
    MODE_E1 = 1'b1
  } frame_mode_e;

  // True when the given bit/frame position carries a datalink bit.
  function automatic logic dl_slot(frame_mode_e m, int unsigned bit_idx,
                                   int unsigned frm_idx, logic nfas,
                                   int unsigned sa_first, int unsigned sa_last);
    if (m == MODE_T1) return (bit_idx == 0) && ((frm_idx % 2) == 0);
    return nfas && (bit_idx >= sa_first) && (bit_idx <= sa_last);
  endfunction

endpackage

// File: rtl/dl_frame_tracker.sv
`timescale 1ns/1ps
module dl_frame_tracker
  import dl_ovh_pkg::*;
#(
  parameter int unsigned T1_BITS   = 193,
  parameter int unsigned E1_BITS   = 256,
  parameter int unsigned MF_FRAMES = 24,
  parameter int unsigned SA_FIRST  = 3,
  parameter int unsigned SA_LAST   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic fsync,
  input  logic msync,
  input  logic fas,
  output logic dl_pos
);
  localparam int unsigned MAXB = (E1_BITS > T1_BITS) ? E1_BITS : T1_BITS;
  localparam int unsigned BW   = $clog2(MAXB);
  localparam int unsigned FW   = $clog2(MF_FRAMES);
  localparam int unsigned SAN  = SA_LAST - SA_FIRST + 1;
  localparam int unsigned RW   = $clog2(SAN + 1);

  logic [BW-1:0] bit_q, cur_bit, last_bit;
  logic [FW-1:0] frm_q, cur_frm;
  logic          nfas_q, cur_nfas, frame_end;
  frame_mode_e   fmode;

  always_comb begin
    fmode     = frame_mode_e'(mode);
    cur_bit   = fsync ? '0 : bit_q;
    cur_frm   = (fsync && msync) ? '0 : frm_q;
    cur_nfas  = fsync ? ~fas : nfas_q;
    last_bit  = (fmode == MODE_E1) ? BW'(E1_BITS - 1) : BW'(T1_BITS - 1);
    frame_end = (cur_bit >= last_bit);
    dl_pos    = dl_slot(fmode, 32'(cur_bit), 32'(cur_frm), cur_nfas,
                        SA_FIRST, SA_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      frm_q  <= '0;
      nfas_q <= 1'b0;
    end else begin
      bit_q  <= frame_end ? '0 : cur_bit + 1'b1;
      if (frame_end)
        frm_q <= (cur_frm >= FW'(MF_FRAMES - 1)) ? '0 : cur_frm + 1'b1;
      else
        frm_q <= cur_frm;
      nfas_q <= frame_end ? ~cur_nfas : cur_nfas;
    end
  end

  // Length of the current run of consecutive datalink positions.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= '0;
    else if (!dl_pos)    run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  assert_t1_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmode == MODE_T1 && dl_pos) |=> (!dl_pos || fsync));

  assert_e1_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmode == MODE_E1) |-> (run_q <= RW'(SAN)));
endmodule

// File: rtl/dl_tx_insert.sv
`timescale 1ns/1ps
module dl_tx_insert (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en,
  input  logic dl_pos,
  input  logic ser_in,
  input  logic oh_data,
  output logic ser_out,
  output logic oh_clk
);
  logic stage_bit;

  // Strobe high for the bit period after the position; data captured
  // at its falling edge and substituted into the delayed stream.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oh_clk    <= 1'b0;
      stage_bit <= 1'b0;
      ser_out   <= 1'b0;
    end else begin
      oh_clk    <= ext_en && dl_pos;
      stage_bit <= ser_in;
      ser_out   <= oh_clk ? oh_data : stage_bit;
    end
  end

  assert_tx_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oh_clk) |-> (ser_out == $past(ser_in, 2)));
endmodule

// File: rtl/dl_rx_extract.sv
`timescale 1ns/1ps
module dl_rx_extract (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en,
  input  logic dl_pos,
  input  logic ser_in,
  output logic ser_out,
  output logic oh_clk,
  output logic oh_data
);
  logic take;
  assign take = ext_en && dl_pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oh_clk  <= 1'b0;
      oh_data <= 1'b0;
      ser_out <= 1'b0;
    end else begin
      oh_clk  <= take;
      ser_out <= ser_in;
      if (take) oh_data <= ser_in;
    end
  end

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oh_clk |-> $stable(oh_data));

  assert_rx_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oh_clk |-> (oh_data == ser_out));
endmodule

// File: rtl/dl_overhead_port.sv
`timescale 1ns/1ps
module dl_overhead_port #(
  parameter int unsigned T1_BITS   = 193,
  parameter int unsigned E1_BITS   = 256,
  parameter int unsigned MF_FRAMES = 24,
  parameter int unsigned SA_FIRST  = 3,
  parameter int unsigned SA_LAST   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic ext_en,
  input  logic tx_fsync,
  input  logic tx_msync,
  input  logic tx_fas,
  input  logic tx_ser_in,
  output logic tx_ser_out,
  output logic tx_oh_clk,
  input  logic tx_oh_data,
  input  logic rx_fsync,
  input  logic rx_msync,
  input  logic rx_fas,
  input  logic rx_ser_in,
  output logic rx_ser_out,
  output logic rx_oh_clk,
  output logic rx_oh_data
);
  localparam int unsigned NDIR = 2;  // 0 = transmit, 1 = receive

  logic [NDIR-1:0] fs, ms, fa, dl_hit;
  assign fs = {rx_fsync, tx_fsync};
  assign ms = {rx_msync, tx_msync};
  assign fa = {rx_fas,   tx_fas};

  for (genvar d = 0; d < NDIR; d++) begin : g_track
    dl_frame_tracker #(
      .T1_BITS(T1_BITS), .E1_BITS(E1_BITS), .MF_FRAMES(MF_FRAMES),
      .SA_FIRST(SA_FIRST), .SA_LAST(SA_LAST)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .fsync(fs[d]), .msync(ms[d]), .fas(fa[d]),
      .dl_pos(dl_hit[d])
    );
  end

  dl_tx_insert u_tx (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .dl_pos(dl_hit[0]),
    .ser_in(tx_ser_in), .oh_data(tx_oh_data),
    .ser_out(tx_ser_out), .oh_clk(tx_oh_clk)
  );

  dl_rx_extract u_rx (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .dl_pos(dl_hit[1]),
    .ser_in(rx_ser_in), .ser_out(rx_ser_out),
    .oh_clk(rx_oh_clk), .oh_data(rx_oh_data)
  );

  assert_bypass_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ext_en) |-> (!tx_oh_clk && !rx_oh_clk));

  assert_rx_unaltered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ser_out == $past(rx_ser_in));
endmodule

// File: tb/dl_overhead_port_test.sv
`timescale 1ns/1ps
module dl_overhead_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, mode, ext_en;
  logic tx_fsync, tx_msync, tx_fas, tx_ser_in, tx_oh_data;
  logic rx_fsync, rx_msync, rx_fas, rx_ser_in;
  logic tx_ser_out, tx_oh_clk, rx_ser_out, rx_oh_clk, rx_oh_data;

  dl_overhead_port uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_en(ext_en),
    .tx_fsync(tx_fsync), .tx_msync(tx_msync), .tx_fas(tx_fas),
    .tx_ser_in(tx_ser_in), .tx_ser_out(tx_ser_out), .tx_oh_clk(tx_oh_clk),
    .tx_oh_data(tx_oh_data),
    .rx_fsync(rx_fsync), .rx_msync(rx_msync), .rx_fas(rx_fas),
    .rx_ser_in(rx_ser_in), .rx_ser_out(rx_ser_out), .rx_oh_clk(rx_oh_clk),
    .rx_oh_data(rx_oh_data)
  );

  int vectors = 0, miscompares = 0;
  int t_tx, t_rx, tx_ofs, ohd_k, pulses;
  logic have_prev, prev_flag, prev_tx_in, cur_flag_tx, cur_flag_rx;
  logic cur_tx_in, cur_rx_in, exp_ohd, realign;
  logic [15:0] lf_tx = 16'hACE1, lf_rx = 16'h1D2B;

  task automatic chk(string req, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b (t_tx=%0d)", req, what, act, exp, t_tx);
    end
  endtask

  task automatic chk_int(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench-side position arithmetic. ofs shifts E1 frame parity.
  function automatic logic is_dl(logic m, int t, int ofs);
    int b;
    if (!m) begin
      b = t % 193;
      return (b == 0) && ((((t / 193) % 24) % 2) == 0);
    end
    b = t % 256;
    return ((((t / 256) + ofs) % 2) == 1) && (b >= 3) && (b <= 7);
  endfunction

  task automatic do_reset(logic m);
    rst_n = 1'b0; mode = m; ext_en = 1'b0;
    tx_fsync = 0; tx_msync = 0; tx_fas = 0; tx_ser_in = 0; tx_oh_data = 0;
    rx_fsync = 0; rx_msync = 0; rx_fas = 0; rx_ser_in = 0;
    repeat (3) @(negedge clk);
    chk("R1", "tx_ser_out in reset", tx_ser_out, 1'b0);
    chk("R1", "tx_oh_clk in reset",  tx_oh_clk,  1'b0);
    chk("R1", "rx_ser_out in reset", rx_ser_out, 1'b0);
    chk("R1", "rx_oh_clk in reset",  rx_oh_clk,  1'b0);
    chk("R1", "rx_oh_data in reset", rx_oh_data, 1'b0);
    rst_n = 1'b1;
    have_prev = 0; prev_flag = 0; prev_tx_in = 0; exp_ohd = 0;
    t_tx = 0; t_rx = 0; ohd_k = 0;
  endtask

  // Run n cycles; when restart is set the transmit stream starts anew at bit 0.
  task automatic run(int n, logic en, logic restart, int ofs);
    if (restart) t_tx = 0;
    tx_ofs = ofs;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (have_prev) begin
        chk(realign ? "R9" : (!en ? "R2" : (mode ? "R4" : "R3")),
            "tx_oh_clk", tx_oh_clk, cur_flag_tx);
        chk("R6", "rx_oh_clk", rx_oh_clk, cur_flag_rx);
        chk("R8", "rx_ser_out", rx_ser_out, cur_rx_in);
        if (cur_flag_rx) exp_ohd = cur_rx_in;
        chk("R7", "rx_oh_data", rx_oh_data, exp_ohd);
        chk(en ? "R5" : "R2", "tx_ser_out", tx_ser_out,
            prev_flag ? tx_oh_data : prev_tx_in);
        if (tx_oh_clk) pulses++;
        prev_flag  = cur_flag_tx;
        prev_tx_in = cur_tx_in;
      end
      // external source: new bit on strobe rise; in bypass it toggles freely
      if (!en) tx_oh_data = ~tx_oh_data;
      else if (tx_oh_clk) begin
        ohd_k++;
        tx_oh_data = ((ohd_k % 3) == 1);
      end
      lf_tx = {lf_tx[14:0], lf_tx[15] ^ lf_tx[13] ^ lf_tx[12] ^ lf_tx[10]};
      lf_rx = {lf_rx[14:0], lf_rx[15] ^ lf_rx[13] ^ lf_rx[12] ^ lf_rx[10]};
      ext_en    = en;
      cur_tx_in = lf_tx[0];
      cur_rx_in = lf_rx[0];
      tx_ser_in = cur_tx_in;
      rx_ser_in = cur_rx_in;
      if (!mode) begin
        tx_fsync = (t_tx % 193) == 0;
        tx_msync = (t_tx % 4632) == 0;
        rx_fsync = (t_rx % 193) == 0;
        rx_msync = (t_rx % 4632) == 0;
        tx_fas = 0; rx_fas = 0;
      end else begin
        tx_fsync = (t_tx % 256) == 0;
        rx_fsync = (t_rx % 256) == 0;
        tx_msync = 0; rx_msync = 0;
        tx_fas = ((((t_tx / 256) + ofs) % 2) == 0);
        rx_fas = (((t_rx / 256) % 2) == 0);
      end
      cur_flag_tx = en && is_dl(mode, t_tx, ofs);
      cur_flag_rx = en && is_dl(mode, t_rx, 0);
      t_tx++; t_rx++;
      have_prev = 1;
    end
  endtask

  initial begin
    realign = 0;
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // T1: two multiframes, 12 strobes each (R3)
    do_reset(1'b0);
    run(2 * 4632, 1'b1, 1'b0, 0);
    chk_int("R3", "T1 strobes per 2 multiframes", pulses, 24);
    // T1 realign mid-frame (R9)
    run(100, 1'b1, 1'b0, 0);
    realign = 1;
    run(4632, 1'b1, 1'b1, 0);
    chk_int("R9", "T1 strobes after realign", pulses, 12);
    realign = 0;
    // T1 bypass (R2)
    run(4632, 1'b0, 1'b0, 0);
    chk_int("R2", "T1 strobes in bypass", pulses, 0);
    // E1: four frames, two non-alignment frames (R4)
    do_reset(1'b1);
    run(4 * 256, 1'b1, 1'b0, 0);
    chk_int("R4", "E1 strobes per 4 frames", pulses, 10);
    // E1 restart with non-alignment frame first (R9)
    realign = 1;
    run(4 * 256, 1'b1, 1'b1, 1);
    chk_int("R9", "E1 strobes with parity from sync", pulses, 10);
    realign = 0;
    // E1 bypass (R2)
    run(2 * 256, 1'b0, 1'b0, 1);
    chk_int("R2", "E1 strobes in bypass", pulses, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule